// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when the memory controller's main sequencer must spend a cycle on an auto-refresh. It also owns the clock-enable line for self refresh. A prescaler counts clock cycles and adds one refresh credit each time a refresh interval ends. The default interval is 781 cycles, which at 100 MHz meets the need of 8192 refreshes in 64 ms. Credits pile up while the sequencer is busy with accesses, to a fixed maximum. At that maximum the request is marked urgent, so the sequencer stops starting new accesses.

The sequencer precharges every bank and then asserts a grant. The block takes the grant only when all banks are idle and no earlier refresh or exit wait is still running. Each grant it takes uses up one credit. It also starts a timer that holds new commands back for the refresh cycle time. The timer flags its last cycle so the sequencer knows when the refresh cycle time has elapsed.

Self refresh is entered by dropping the clock enable. While the part is in self refresh, the prescaler stops and the credits are frozen. On exit the clock enable rises, the credits are cleared, and commands stay held for the refresh cycle time plus the minimum exit time.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset the credit level is 0, refReq, refUrgent, refBusy, refDone, cmdHold and inSelfRefresh are low, and cke is high.
- R2: Outside self refresh, the credit level rises by one on every INTERVAL_CYC-th rising clock edge counted from reset release. refReq is high exactly when the credit level is nonzero.
- R3: The credit level saturates at MAX_CREDIT. refUrgent is high exactly when the level equals MAX_CREDIT.
- R4: A grant is taken only when all of these hold: the credit level is nonzero, banksIdle is high, cmdHold is low, and the block is not in self refresh. In any other case the grant leaves the credit level and refBusy unchanged.
- R5: A grant that is taken removes one credit. refBusy and cmdHold are then high for exactly TRFC_CYC cycles, starting in the cycle after the grant.
- R6: refDone is high only in the last cycle of each refBusy window.
- R7: When a grant is taken on the same edge as an interval end, the credit level stays the same.
- R8: A self-refresh entry request is taken only when banksIdle is high, cmdHold is low, no grant is taken in that cycle, and the block is not already in self refresh. In the next cycle cke is low and inSelfRefresh is high. A request that does not meet these conditions has no effect.
- R9: In self refresh the prescaler holds its count, the credit level does not change, and grants are ignored. After exit, counting resumes from the held count.
- R10: An exit request during self refresh raises cke and clears the credit level in the next cycle. From that cycle, cmdHold stays high for TRFC_CYC + EXIT_MIN_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| banksIdle | input | 1 | All banks are precharged |
| grantRef | input | 1 | Sequencer grants a refresh slot |
| srEnterReq | input | 1 | Request to enter self refresh |
| srExitReq | input | 1 | Request to leave self refresh |
| refReq | output | 1 | At least one refresh is owed |
| refUrgent | output | 1 | Credits at maximum; block new accesses |
| creditLevel | output | $clog2(MAX_CREDIT+1) | Refreshes currently owed |
| refBusy | output | 1 | Refresh cycle time is running |
| refDone | output | 1 | Last cycle of the refresh cycle time |
| cmdHold | output | 1 | No new command may be issued |
| cke | output | 1 | Clock enable to the memory |
| inSelfRefresh | output | 1 | Memory is in self refresh |

## Verification
The bench sets a grant on the same edge as an interval end. A design that counted both events would lose a credit or gain one. It pushes the credit level to saturation and checks that it stays at the cap. A wrapping counter would drop to zero there and hide an overdue refresh. It tries grants and self-refresh entry while a refresh is still running, and tries grants during self refresh. A design that ignored the hold would shorten the refresh cycle time. The bench also counts cycles after a self-refresh exit. This checks both the exact length of the hold and the point where the prescaler resumes, so an off-by-one in either window, or a timer that keeps counting in self refresh, moves the first new credit.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_SELF = 1'b1
  } rfshState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic prescEn;
    logic creditDec;
    logic creditClr;
    logic busyLoad;
    logic holdLoad;
  } rfshStrobes_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int INTERVAL_CYC  = 781,
  parameter int MAX_CREDIT    = 8,
  parameter int TRFC_CYC      = 7,
  parameter int EXIT_HOLD_CYC = 8,
  localparam int PW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1,
  localparam int CW = $clog2(MAX_CREDIT + 1),
  localparam int TW = $clog2(TRFC_CYC + 1),
  localparam int HW = $clog2(EXIT_HOLD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rfshStrobes_t  strobes,
  output logic [CW-1:0] creditLevel,
  output logic          busyActive,
  output logic          busyLast,
  output logic          holdActive
);

  localparam logic [PW-1:0] PRESC_LAST = PW'(INTERVAL_CYC - 1);
  localparam logic [CW-1:0] CREDIT_MAX = CW'(MAX_CREDIT);
  localparam logic [TW-1:0] BUSY_INIT  = TW'(TRFC_CYC);
  localparam logic [HW-1:0] HOLD_INIT  = HW'(EXIT_HOLD_CYC);

  logic [PW-1:0] prescCnt;
  logic [CW-1:0] creditCnt;
  logic [TW-1:0] busyCnt;
  logic [HW-1:0] holdCnt;
  logic          intervalTick;
  logic          creditFull;

  assign intervalTick = strobes.prescEn && (prescCnt == PRESC_LAST);
  assign creditFull   = (creditCnt == CREDIT_MAX);

  // interval prescaler: frozen when prescEn is low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (strobes.prescEn) begin
      if (prescCnt == PRESC_LAST) prescCnt <= '0;
      else                        prescCnt <= prescCnt + 1'b1;
    end
  end

  // credit counter: saturating, tick and grant on one edge cancel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      creditCnt <= '0;
    end else if (strobes.creditClr) begin
      creditCnt <= '0;
    end else begin
      unique case ({intervalTick, strobes.creditDec})
        2'b10:   if (!creditFull) creditCnt <= creditCnt + 1'b1;
        2'b01:   creditCnt <= creditCnt - 1'b1;
        default: creditCnt <= creditCnt;
      endcase
    end
  end

  // refresh cycle time window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strobes.busyLoad) begin
      busyCnt <= BUSY_INIT;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  // hold-off window after self-refresh exit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobes.holdLoad) begin
      holdCnt <= HOLD_INIT;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign creditLevel = creditCnt;
  assign busyActive  = (busyCnt != '0);
  assign busyLast    = (busyCnt == TW'(1));
  assign holdActive  = (holdCnt != '0);

endmodule

// File: rtl/rfsh_control.sv
module rfsh_control
  import rfsh_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          banksIdle,
  input  logic          grantRef,
  input  logic          srEnterReq,
  input  logic          srExitReq,
  input  logic [CW-1:0] creditLevel,
  input  logic          busyActive,
  input  logic          holdActive,
  output rfshStrobes_t  strobes,
  output logic          inSelf
);

  rfshState_t state;
  logic       blocked;
  logic       grantOk;
  logic       enterOk;
  logic       exitOk;

  assign blocked = busyActive || holdActive;
  assign grantOk = (state == ST_RUN) && grantRef && banksIdle && !blocked
                   && (creditLevel != '0);
  assign enterOk = (state == ST_RUN) && srEnterReq && banksIdle && !blocked
                   && !grantOk;
  assign exitOk  = (state == ST_SELF) && srExitReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
    end else begin
      unique case (state)
        ST_RUN:  if (enterOk) state <= ST_SELF;
        ST_SELF: if (exitOk)  state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.prescEn   = (state == ST_RUN);
    strobes.creditDec = grantOk;
    strobes.busyLoad  = grantOk;
    strobes.creditClr = exitOk;
    strobes.holdLoad  = exitOk;
  end

  assign inSelf = (state == ST_SELF);

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int INTERVAL_CYC = 781,
  parameter int MAX_CREDIT   = 8,
  parameter int TRFC_CYC     = 7,
  parameter int EXIT_MIN_CYC = 1,
  localparam int CW = $clog2(MAX_CREDIT + 1),
  localparam int EXIT_HOLD_CYC = TRFC_CYC + EXIT_MIN_CYC
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          banksIdle,
  input  logic          grantRef,
  input  logic          srEnterReq,
  input  logic          srExitReq,
  output logic          refReq,
  output logic          refUrgent,
  output logic [CW-1:0] creditLevel,
  output logic          refBusy,
  output logic          refDone,
  output logic          cmdHold,
  output logic          cke,
  output logic          inSelfRefresh
);

  rfshStrobes_t strobes;
  logic [CW-1:0] creditCnt;
  logic busyActive;
  logic busyLast;
  logic holdActive;
  logic inSelf;

  rfsh_control #(.CW(CW)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .banksIdle  (banksIdle),
    .grantRef   (grantRef),
    .srEnterReq (srEnterReq),
    .srExitReq  (srExitReq),
    .creditLevel(creditCnt),
    .busyActive (busyActive),
    .holdActive (holdActive),
    .strobes    (strobes),
    .inSelf     (inSelf)
  );

  rfsh_datapath #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .MAX_CREDIT   (MAX_CREDIT),
    .TRFC_CYC     (TRFC_CYC),
    .EXIT_HOLD_CYC(EXIT_HOLD_CYC)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .creditLevel(creditCnt),
    .busyActive (busyActive),
    .busyLast   (busyLast),
    .holdActive (holdActive)
  );

  assign creditLevel   = creditCnt;
  assign refReq        = (creditCnt != '0);
  assign refUrgent     = (creditCnt == CW'(MAX_CREDIT));
  assign refBusy       = busyActive;
  assign refDone       = busyLast;
  assign cmdHold       = busyActive || holdActive;
  assign cke           = !inSelf;
  assign inSelfRefresh = inSelf;

endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker #(
  parameter int MAX_CREDIT = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          banksIdle,
  input logic          grantRef,
  input logic          srEnterReq,
  input logic [CW-1:0] creditLevel,
  input logic          refBusy,
  input logic          refDone,
  input logic          cmdHold,
  input logic          cke,
  input logic          inSelfRefresh
);

  // R3
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(creditLevel) <= MAX_CREDIT);

  // R2
  credit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (creditLevel != $past(creditLevel)) |->
      (int'(creditLevel) == int'($past(creditLevel)) + 1 ||
       int'(creditLevel) == int'($past(creditLevel)) - 1 ||
       creditLevel == '0));

  // R9
  sr_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inSelfRefresh && $past(inSelfRefresh)) |-> $stable(creditLevel));

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refBusy) |-> $past(grantRef && banksIdle && !cmdHold));

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    refDone |=> !refBusy);

  // R8
  sr_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> $past(srEnterReq && banksIdle && !cmdHold));

  // R10
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (cmdHold && creditLevel == '0));

endmodule

bind sdram_refresh_sched rfsh_checker #(
  .MAX_CREDIT(MAX_CREDIT),
  .CW        (CW)
) chk (
  .clk          (clk),
  .rstN         (rstN),
  .banksIdle    (banksIdle),
  .grantRef     (grantRef),
  .srEnterReq   (srEnterReq),
  .creditLevel  (creditLevel),
  .refBusy      (refBusy),
  .refDone      (refDone),
  .cmdHold      (cmdHold),
  .cke          (cke),
  .inSelfRefresh(inSelfRefresh)
);

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;

  localparam int P    = 40;
  localparam int MAXC = 8;
  localparam int TRFC = 7;
  localparam int EXM  = 1;
  localparam int HOLD = TRFC + EXM;
  localparam int CW   = $clog2(MAXC + 1);

  localparam int S_CREDIT = 0;
  localparam int S_REQ    = 1;
  localparam int S_URG    = 2;
  localparam int S_BUSY   = 3;
  localparam int S_DONE   = 4;
  localparam int S_CKE    = 5;
  localparam int S_SELF   = 6;
  localparam int S_HOLD   = 7;

  typedef struct {
    int    cyc;
    int    sig;
    int    val;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic banksIdle = 1'b1;
  logic grantRef = 1'b0;
  logic srEnterReq = 1'b0;
  logic srExitReq = 1'b0;
  logic refReq, refUrgent, refBusy, refDone, cmdHold, cke, inSelfRefresh;
  logic [CW-1:0] creditLevel;

  int posCnt = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  sdram_refresh_sched #(
    .INTERVAL_CYC(P),
    .MAX_CREDIT  (MAXC),
    .TRFC_CYC    (TRFC),
    .EXIT_MIN_CYC(EXM)
  ) uut (
    .clk          (clk),
    .rstN         (rstN),
    .banksIdle    (banksIdle),
    .grantRef     (grantRef),
    .srEnterReq   (srEnterReq),
    .srExitReq    (srExitReq),
    .refReq       (refReq),
    .refUrgent    (refUrgent),
    .creditLevel  (creditLevel),
    .refBusy      (refBusy),
    .refDone      (refDone),
    .cmdHold      (cmdHold),
    .cke          (cke),
    .inSelfRefresh(inSelfRefresh)
  );

  always @(posedge clk) posCnt <= posCnt + 1;

  function automatic int sigVal(int s);
    case (s)
      S_CREDIT: return int'(creditLevel);
      S_REQ:    return int'(refReq);
      S_URG:    return int'(refUrgent);
      S_BUSY:   return int'(refBusy);
      S_DONE:   return int'(refDone);
      S_CKE:    return int'(cke);
      S_SELF:   return int'(inSelfRefresh);
      default:  return int'(cmdHold);
    endcase
  endfunction

  function automatic string sigName(int s);
    case (s)
      S_CREDIT: return "creditLevel";
      S_REQ:    return "refReq";
      S_URG:    return "refUrgent";
      S_BUSY:   return "refBusy";
      S_DONE:   return "refDone";
      S_CKE:    return "cke";
      S_SELF:   return "inSelfRefresh";
      default:  return "cmdHold";
    endcase
  endfunction

  // driver side: queue an expectation for the current sampling point
  task automatic expectNow(int s, int v, string req);
    expItem_t it;
    it.cyc = posCnt;
    it.sig = s;
    it.val = v;
    it.req = req;
    expQ.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations away from the clock edge
  always @(negedge clk) begin
    #1;
    while (expQ.size() > 0 && expQ[0].cyc <= posCnt) begin
      expItem_t it;
      int act;
      it = expQ.pop_front();
      act = sigVal(it.sig);
      checks++;
      if (it.cyc != posCnt || act != it.val) begin
        errors++;
        $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)",
                 it.req, sigName(it.sig), act, it.val, it.cyc);
      end
    end
  end

  always @(posedge clk) begin
    if (!finished && posCnt > 5000) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    expectNow(S_CREDIT, 0, "R1");
    expectNow(S_REQ, 0, "R1");
    expectNow(S_URG, 0, "R1");
    expectNow(S_BUSY, 0, "R1");
    expectNow(S_DONE, 0, "R1");
    expectNow(S_HOLD, 0, "R1");
    expectNow(S_CKE, 1, "R1");
    expectNow(S_SELF, 0, "R1");
    rstN = 1'b1;

    // R2 first interval end
    step(P - 1);
    expectNow(S_CREDIT, 0, "R2");
    expectNow(S_REQ, 0, "R2");
    step(1);
    expectNow(S_CREDIT, 1, "R2");
    expectNow(S_REQ, 1, "R2");

    // R4 grant while banks not idle is ignored
    grantRef = 1'b1;
    banksIdle = 1'b0;
    step(1);
    expectNow(S_CREDIT, 1, "R4");
    expectNow(S_BUSY, 0, "R4");
    banksIdle = 1'b1;
    step(1);
    grantRef = 1'b0;
    // R5 grant taken
    expectNow(S_CREDIT, 0, "R5");
    expectNow(S_REQ, 0, "R5");
    expectNow(S_BUSY, 1, "R5");
    expectNow(S_HOLD, 1, "R5");
    step(5);
    expectNow(S_BUSY, 1, "R5");
    expectNow(S_DONE, 0, "R6");
    step(1);
    expectNow(S_BUSY, 1, "R5");
    expectNow(S_DONE, 1, "R6");
    step(1);
    expectNow(S_BUSY, 0, "R5");
    expectNow(S_HOLD, 0, "R5");
    expectNow(S_DONE, 0, "R6");

    // R7 grant on an interval-end edge (edge 3P)
    step(2 * P - 10);
    expectNow(S_CREDIT, 1, "R7");
    grantRef = 1'b1;
    step(1);
    grantRef = 1'b0;
    expectNow(S_CREDIT, 1, "R7");
    expectNow(S_BUSY, 1, "R7");

    // R3 saturation
    step(7 * P - 1);
    expectNow(S_CREDIT, 7, "R3");
    expectNow(S_URG, 0, "R3");
    step(1);
    expectNow(S_CREDIT, 8, "R3");
    expectNow(S_URG, 1, "R3");
    step(P);
    expectNow(S_CREDIT, 8, "R3");
    expectNow(S_URG, 1, "R3");

    // R4 second grant blocked by running refresh
    grantRef = 1'b1;
    step(1);
    expectNow(S_CREDIT, 7, "R5");
    expectNow(S_URG, 0, "R3");
    expectNow(S_BUSY, 1, "R5");
    step(1);
    expectNow(S_CREDIT, 7, "R4");
    grantRef = 1'b0;

    // R8 entry during busy ignored
    srEnterReq = 1'b1;
    step(1);
    expectNow(S_CKE, 1, "R8");
    expectNow(S_SELF, 0, "R8");
    srEnterReq = 1'b0;
    step(5);
    expectNow(S_BUSY, 0, "R5");
    srEnterReq = 1'b1;
    step(1);
    srEnterReq = 1'b0;
    expectNow(S_CKE, 0, "R8");
    expectNow(S_SELF, 1, "R8");

    // R9 frozen in self refresh, grants ignored
    step(3 * P);
    expectNow(S_CREDIT, 7, "R9");
    grantRef = 1'b1;
    step(1);
    grantRef = 1'b0;
    expectNow(S_CREDIT, 7, "R9");
    expectNow(S_BUSY, 0, "R9");

    // R10 exit
    srExitReq = 1'b1;
    step(1);                    // k = 1
    srExitReq = 1'b0;
    expectNow(S_CKE, 1, "R10");
    expectNow(S_SELF, 0, "R10");
    expectNow(S_CREDIT, 0, "R10");
    expectNow(S_HOLD, 1, "R10");
    srEnterReq = 1'b1;
    step(1);                    // k = 2
    srEnterReq = 1'b0;
    expectNow(S_CKE, 1, "R8");
    expectNow(S_SELF, 0, "R8");
    step(5);                    // k = 7
    expectNow(S_HOLD, 1, "R10");
    step(1);                    // k = 8
    expectNow(S_HOLD, 1, "R10");
    step(1);                    // k = 9
    expectNow(S_HOLD, 0, "R10");

    // R9 prescaler resumes from held count (9)
    step(P - 9 - 9);            // k = P-9
    expectNow(S_CREDIT, 0, "R9");
    step(1);                    // k = P-8
    expectNow(S_CREDIT, 1, "R9");
    expectNow(S_REQ, 1, "R2");

    step(2);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", expQ.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule